// File: doc/BRIEF.md
# Nested-Loop Array Address Generator

This block walks a two-dimensional array held in memory and produces one memory address per clock cycle. The walk is set by a small set of parameters that are latched on a start strobe. Each of up to four nested loop levels has a trip count and a signed step with a row part and a column part. Level 1 is the innermost loop. An origin gives the first row and column index. The current row index is the origin plus, for every level, that level's completed-step count times its row step. The column index is formed the same way.

Each row and column index passes through a boundary stage before use. In wrap mode, an index that falls outside its dimension is folded back by one dimension length. In zero-fill mode, such an index raises a zero-fill flag instead. The consumer then substitutes zero data for that element. The address is the column index times the row length, plus the row index, plus a base address. One pass over the array can read a sliding window, a transposed matrix or a block of sub-windows, with no code beyond the parameters.

Top module: `nest_addr_gen`

## Requirements
- R1: The parameters are latched on the clock edge where `start_i` is high; call it the load edge. The first address appears at `valid_o` 3 edges after the load edge. One address follows per cycle after that, with no gaps, until the transfer ends.
- R2: Level 1 steps fastest. When a level has completed its trip count, the level counts and steps restart at zero, and the next level advances by one step.
- R3: Each level's step has independent row and column parts. A level that steps only the column makes a column-first (transposed) walk.
- R4: A trip count of 0 marks a level as unused, and so does every level above it, whatever their values. The number of addresses equals the product of the used trip counts.
- R5: If level 1 has a trip count of 0, `valid_o` stays low for the whole transfer. `done_o` still pulses once, 4 edges after the load edge.
- R6: In wrap mode (`zero_fill_i`=0), a negative index has its dimension length added. An index greater than or equal to its length has the length subtracted. The row index uses the row length and the column index uses the column length.
- R7: In zero-fill mode (`zero_fill_i`=1), an out-of-range row or column index sets `zfill_o` with that address. `addr_o` then equals the base address.
- R8: `addr_o` = base + column index × row length + row index, using the adjusted indices.
- R9: `done_o` is high for exactly one cycle, in the cycle after the last valid address. `valid_o` is low in that cycle. A 7-long window stepped by 2 for 25 windows yields 175 addresses: row indices 0..6, then 2..8, and so on.
- R10: While reset is asserted, `valid_o`, `zfill_o` and `done_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Latch parameters and begin a transfer |
| len_i | input | NUM_LVL*LEN_W | Trip count per level, level 1 in the low slice |
| drow_i | input | NUM_LVL*IDX_W | Signed row step per level |
| dcol_i | input | NUM_LVL*IDX_W | Signed column step per level |
| org_row_i | input | IDX_W | Signed origin row index |
| org_col_i | input | IDX_W | Signed origin column index |
| row_len_i | input | DIM_W | Row length (elements per row) |
| col_len_i | input | DIM_W | Column length (number of rows) |
| base_i | input | ADDR_W | Base address of the array |
| zero_fill_i | input | 1 | 0 = wrap mode, 1 = zero-fill mode |
| addr_o | output | ADDR_W | Generated memory address |
| zfill_o | output | 1 | Current element is outside the array (zero-fill mode) |
| valid_o | output | 1 | `addr_o` holds an address of the walk |
| done_o | output | 1 | One-cycle pulse after the final address |

## Verification
A corrupted loop counter or accumulator shows up at the ports as a wrong address on the very next valid cycle. It may also show up as a wrong number of addresses, or as `done_o` firing early or late, so the bench compares every address against an arithmetic model. A broken carry between levels first appears at the address after a level boundary, for example the eighth address of the sliding window. Errors in the boundary stage show up as a wrong folded address or a wrong `zfill_o` on the first element that leaves the array. A small-array sweep covers negative and positive steps in both modes.

// File: rtl/nag_pkg.sv
package nag_pkg;
  typedef enum logic {
    BND_WRAP = 1'b0,
    BND_ZERO = 1'b1
  } bnd_mode_e;
endpackage

// File: rtl/nag_loop_seq.sv
module nag_loop_seq #(
  parameter int NUM_LVL = 4,
  parameter int LEN_W   = 10,
  parameter int IDX_W   = 12,
  parameter int ACC_W   = 22
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic [NUM_LVL*LEN_W-1:0] len_i,
  input  logic [NUM_LVL*IDX_W-1:0] drow_i,
  input  logic [NUM_LVL*IDX_W-1:0] dcol_i,
  output logic                     vld_o,
  output logic                     last_o,
  output logic [NUM_LVL*ACC_W-1:0] acc_row_o,
  output logic [NUM_LVL*ACC_W-1:0] acc_col_o
);
  localparam int LVL_W = $clog2(NUM_LVL);

  logic [LVL_W-1:0]   top_q, top_d;
  logic               run_q, empty_q;
  logic [NUM_LVL:0]   carry;
  logic [NUM_LVL-1:0] wrap, used, fin_vec;
  logic               fin;

  // highest level reached before the first zero trip count
  always_comb begin
    top_d = '0;
    for (int l = 1; l < NUM_LVL; l++)
      if (len_i[l*LEN_W +: LEN_W] != '0 && top_d == LVL_W'(l - 1)) top_d = LVL_W'(l);
  end

  assign carry[0] = 1'b1;

  for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
    logic        [LEN_W-1:0] len_q, cnt_q;
    logic signed [IDX_W-1:0] drow_q, dcol_q;
    logic signed [ACC_W-1:0] arow_q, acol_q;

    assign used[l]     = (top_q >= LVL_W'(l));
    assign wrap[l]     = (cnt_q == len_q - LEN_W'(1));
    assign fin_vec[l]  = wrap[l] | ~used[l];
    assign carry[l+1]  = carry[l] & wrap[l];
    assign acc_row_o[l*ACC_W +: ACC_W] = arow_q;
    assign acc_col_o[l*ACC_W +: ACC_W] = acol_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        len_q  <= '0;
        cnt_q  <= '0;
        drow_q <= '0;
        dcol_q <= '0;
        arow_q <= '0;
        acol_q <= '0;
      end else if (start_i) begin
        len_q  <= len_i[l*LEN_W +: LEN_W];
        drow_q <= $signed(drow_i[l*IDX_W +: IDX_W]);
        dcol_q <= $signed(dcol_i[l*IDX_W +: IDX_W]);
        cnt_q  <= '0;
        arow_q <= '0;
        acol_q <= '0;
      end else if (run_q && carry[l] && used[l]) begin
        if (wrap[l]) begin
          cnt_q  <= '0;
          arow_q <= '0;
          acol_q <= '0;
        end else begin
          cnt_q  <= cnt_q + LEN_W'(1);
          arow_q <= arow_q + ACC_W'(drow_q);
          acol_q <= acol_q + ACC_W'(dcol_q);
        end
      end
    end

    AST_CNT_BELOW_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_q && used[l]) |-> (cnt_q < len_q)); // R2
  end

  assign fin = &fin_vec;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      empty_q <= 1'b0;
      top_q   <= '0;
    end else if (start_i) begin
      run_q   <= (len_i[LEN_W-1:0] != '0);
      empty_q <= (len_i[LEN_W-1:0] == '0);
      top_q   <= top_d;
    end else begin
      empty_q <= 1'b0;
      if (run_q && fin) run_q <= 1'b0;
    end
  end

  assign vld_o  = run_q;
  assign last_o = (run_q & fin) | empty_q;

  AST_RUN_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !fin && !start_i) |=> run_q); // R1
endmodule

// File: rtl/nag_bound_adj.sv
module nag_bound_adj #(
  parameter int SUM_W = 24,
  parameter int DIM_W = 10
) (
  input  logic signed [SUM_W-1:0] idx_i,
  input  logic        [DIM_W-1:0] len_i,
  input  nag_pkg::bnd_mode_e      mode_i,
  output logic        [DIM_W-1:0] idx_o,
  output logic                    zf_o
);
  logic signed [SUM_W-1:0] len_s, fixed;
  logic lo, hi;

  assign len_s = SUM_W'(len_i);
  assign lo    = idx_i < 0;
  assign hi    = idx_i >= len_s;

  always_comb begin
    if (lo)      fixed = idx_i + len_s;
    else if (hi) fixed = idx_i - len_s;
    else         fixed = idx_i;
  end

  assign zf_o  = (mode_i == nag_pkg::BND_ZERO) && (lo || hi);
  assign idx_o = zf_o ? '0 : fixed[DIM_W-1:0];
endmodule

// File: rtl/nag_addr_calc.sv
module nag_addr_calc #(
  parameter int DIM_W  = 10,
  parameter int ADDR_W = 24
) (
  input  logic [DIM_W-1:0]  row_i,
  input  logic [DIM_W-1:0]  col_i,
  input  logic [DIM_W-1:0]  row_len_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              zf_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [2*DIM_W-1:0] prod;

  assign prod   = col_i * row_len_i;
  assign addr_o = zf_i ? base_i : base_i + ADDR_W'(prod) + ADDR_W'(row_i);
endmodule

// File: rtl/nest_addr_gen.sv
module nest_addr_gen #(
  parameter int NUM_LVL = 4,
  parameter int LEN_W   = 10,
  parameter int IDX_W   = 12,
  parameter int DIM_W   = 10,
  parameter int ADDR_W  = 24
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic [NUM_LVL*LEN_W-1:0] len_i,
  input  logic [NUM_LVL*IDX_W-1:0] drow_i,
  input  logic [NUM_LVL*IDX_W-1:0] dcol_i,
  input  logic [IDX_W-1:0]         org_row_i,
  input  logic [IDX_W-1:0]         org_col_i,
  input  logic [DIM_W-1:0]         row_len_i,
  input  logic [DIM_W-1:0]         col_len_i,
  input  logic [ADDR_W-1:0]        base_i,
  input  logic                     zero_fill_i,
  output logic [ADDR_W-1:0]        addr_o,
  output logic                     zfill_o,
  output logic                     valid_o,
  output logic                     done_o
);
  localparam int ACC_W = IDX_W + LEN_W;
  localparam int SUM_W = ACC_W + $clog2(NUM_LVL + 1);

  logic signed [IDX_W-1:0] org_row_q, org_col_q;
  logic [DIM_W-1:0]        row_len_q, col_len_q;
  logic [ADDR_W-1:0]       base_q;
  nag_pkg::bnd_mode_e      mode_q;

  logic                     seq_vld, seq_last;
  logic [NUM_LVL*ACC_W-1:0] acc_row, acc_col;
  logic signed [SUM_W-1:0]  row_sum, col_sum;

  logic                    s1_vld, s1_last;
  logic signed [SUM_W-1:0] s1_row, s1_col;
  logic [DIM_W-1:0]        adj_row, adj_col, s2_row, s2_col;
  logic                    zf_row, zf_col, s2_vld, s2_last, s2_zf;
  logic [ADDR_W-1:0]       addr_d;
  logic                    last3;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      org_row_q <= '0;
      org_col_q <= '0;
      row_len_q <= '0;
      col_len_q <= '0;
      base_q    <= '0;
      mode_q    <= nag_pkg::BND_WRAP;
    end else if (start_i) begin
      org_row_q <= $signed(org_row_i);
      org_col_q <= $signed(org_col_i);
      row_len_q <= row_len_i;
      col_len_q <= col_len_i;
      base_q    <= base_i;
      mode_q    <= zero_fill_i ? nag_pkg::BND_ZERO : nag_pkg::BND_WRAP;
    end
  end

  nag_loop_seq #(
    .NUM_LVL(NUM_LVL), .LEN_W(LEN_W), .IDX_W(IDX_W), .ACC_W(ACC_W)
  ) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .len_i    (len_i),
    .drow_i   (drow_i),
    .dcol_i   (dcol_i),
    .vld_o    (seq_vld),
    .last_o   (seq_last),
    .acc_row_o(acc_row),
    .acc_col_o(acc_col)
  );

  always_comb begin
    row_sum = SUM_W'(org_row_q);
    col_sum = SUM_W'(org_col_q);
    for (int l = 0; l < NUM_LVL; l++) begin
      row_sum = row_sum + SUM_W'($signed(acc_row[l*ACC_W +: ACC_W]));
      col_sum = col_sum + SUM_W'($signed(acc_col[l*ACC_W +: ACC_W]));
    end
  end

  // stage 1: raw indices
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_vld  <= 1'b0;
      s1_last <= 1'b0;
      s1_row  <= '0;
      s1_col  <= '0;
    end else begin
      s1_vld  <= seq_vld;
      s1_last <= seq_last;
      s1_row  <= row_sum;
      s1_col  <= col_sum;
    end
  end

  nag_bound_adj #(.SUM_W(SUM_W), .DIM_W(DIM_W)) u_adj_row (
    .idx_i(s1_row), .len_i(row_len_q), .mode_i(mode_q), .idx_o(adj_row), .zf_o(zf_row)
  );
  nag_bound_adj #(.SUM_W(SUM_W), .DIM_W(DIM_W)) u_adj_col (
    .idx_i(s1_col), .len_i(col_len_q), .mode_i(mode_q), .idx_o(adj_col), .zf_o(zf_col)
  );

  // stage 2: adjusted indices
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s2_vld  <= 1'b0;
      s2_last <= 1'b0;
      s2_zf   <= 1'b0;
      s2_row  <= '0;
      s2_col  <= '0;
    end else begin
      s2_vld  <= s1_vld;
      s2_last <= s1_last;
      s2_zf   <= zf_row | zf_col;
      s2_row  <= adj_row;
      s2_col  <= adj_col;
    end
  end

  nag_addr_calc #(.DIM_W(DIM_W), .ADDR_W(ADDR_W)) u_addr (
    .row_i(s2_row), .col_i(s2_col), .row_len_i(row_len_q),
    .base_i(base_q), .zf_i(s2_zf), .addr_o(addr_d)
  );

  // stage 3: outputs
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o  <= '0;
      zfill_o <= 1'b0;
      valid_o <= 1'b0;
      last3   <= 1'b0;
      done_o  <= 1'b0;
    end else begin
      addr_o  <= addr_d;
      zfill_o <= s2_vld & s2_zf;
      valid_o <= s2_vld;
      last3   <= s2_last;
      done_o  <= last3;
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9
  AST_DONE_NO_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !valid_o); // R9
  AST_WRAP_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s2_vld && !s2_zf) |-> (s2_row < row_len_q && s2_col < col_len_q)); // R6
  AST_ZF_AT_BASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && zfill_o) |-> (addr_o == base_q)); // R7
endmodule

// File: tb/nest_addr_gen_bench.sv
`timescale 1ns/1ps
module nest_addr_gen_bench;
  localparam int NL = 4, LW = 10, IW = 12, DW = 10, AW = 24;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [NL*LW-1:0] len_v = '0;
  logic [NL*IW-1:0] drow_v = '0, dcol_v = '0;
  logic [IW-1:0] orow_v = '0, ocol_v = '0;
  logic [DW-1:0] rl_v = '0, cl_v = '0;
  logic [AW-1:0] base_v = '0;
  logic zm_v = 1'b0;
  logic [AW-1:0] addr;
  logic zf, vld, done;

  int checks = 0, fails = 0;
  int L[4], dr[4], dc[4];
  int orow, ocol, rl, cl, base;
  bit zm;

  always #2 clk = ~clk;

  nest_addr_gen u_nest_addr_gen (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .len_i(len_v), .drow_i(drow_v),
    .dcol_i(dcol_v), .org_row_i(orow_v), .org_col_i(ocol_v), .row_len_i(rl_v),
    .col_len_i(cl_v), .base_i(base_v), .zero_fill_i(zm_v), .addr_o(addr),
    .zfill_o(zf), .valid_o(vld), .done_o(done)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic void fold(input int v, input int len, input bit z_mode, output int o, output bit z);
    z = 1'b0;
    o = v;
    if (v < 0 || v >= len) begin
      if (z_mode) begin z = 1'b1; o = 0; end
      else if (v < 0) o = v + len;
      else o = v - len;
    end
  endfunction

  task automatic clear_cfg();
    for (int l = 0; l < 4; l++) begin L[l] = 0; dr[l] = 0; dc[l] = 0; end
    orow = 0; ocol = 0; rl = 8; cl = 8; base = 0; zm = 1'b0;
  endtask

  task automatic run_case(input string tag);
    int exp_a[$];
    bit exp_z[$];
    int tot, nu, idx, done_k, exp_done;
    nu = 0; tot = 1;
    for (int l = 0; l < 4; l++) begin
      if (L[l] == 0) break;
      tot *= L[l]; nu++;
    end
    if (nu == 0) tot = 0;
    for (int k = 0; k < tot; k++) begin
      int rem, r, c, ra, ca;
      bit zr, zc;
      rem = k; r = orow; c = ocol;
      for (int l = 0; l < nu; l++) begin
        r += (rem % L[l]) * dr[l];
        c += (rem % L[l]) * dc[l];
        rem /= L[l];
      end
      fold(r, rl, zm, ra, zr);
      fold(c, cl, zm, ca, zc);
      exp_z.push_back(zr | zc);
      exp_a.push_back((zr | zc) ? base : base + ca * rl + ra);
    end
    @(negedge clk);
    for (int l = 0; l < 4; l++) begin
      len_v[l*LW +: LW]  = LW'(L[l]);
      drow_v[l*IW +: IW] = IW'(dr[l]);
      dcol_v[l*IW +: IW] = IW'(dc[l]);
    end
    orow_v = IW'(orow); ocol_v = IW'(ocol);
    rl_v = DW'(rl); cl_v = DW'(cl); base_v = AW'(base); zm_v = zm;
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    idx = 0; done_k = 0;
    for (int k = 1; k <= tot + 8; k++) begin
      if (vld) begin
        if (idx >= tot) chk(1'b0, "R4", "extra address", idx + 1, tot);
        else begin
          chk(k == 4 + idx, "R1", "address slot", k, 4 + idx);
          chk(addr == AW'(exp_a[idx]), tag, "address", int'(addr), exp_a[idx]);
          chk(zf == exp_z[idx], tag, "zero-fill flag", int'(zf), int'(exp_z[idx]));
        end
        idx++;
      end
      if (done) begin
        if (done_k != 0) chk(1'b0, "R9", "second done pulse", k, done_k);
        else done_k = k;
      end
      @(negedge clk);
    end
    chk(idx == tot, "R4", "address count", idx, tot);
    exp_done = (tot == 0 ? 1 : tot) + 4;
    chk(done_k == exp_done, tot == 0 ? "R5" : "R9", "done slot", done_k, exp_done);
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(vld == 1'b0, "R10", "valid in reset", int'(vld), 0);
    chk(done == 1'b0, "R10", "done in reset", int'(done), 0);
    chk(zf == 1'b0, "R10", "zfill in reset", int'(zf), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // sliding window: 7 wide, step 2, 25 windows
    clear_cfg(); L[0] = 7; dr[0] = 1; L[1] = 25; dr[1] = 2; rl = 64; cl = 4; base = 100;
    run_case("R9");
    // transposed 3x5 read
    clear_cfg(); L[0] = 3; dc[0] = 1; L[1] = 5; dr[1] = 1; rl = 5; cl = 3; base = 7;
    run_case("R3");
    // block of windows over a matrix
    clear_cfg(); L[0] = 3; dr[0] = 1; L[1] = 4; dr[1] = 2; L[2] = 2; dc[2] = 1; rl = 10; cl = 4; base = 300;
    run_case("R8");
    // all four levels
    clear_cfg(); L[0] = 2; dr[0] = 1; L[1] = 2; dc[1] = 1; L[2] = 2; dr[2] = 3; L[3] = 2; dc[3] = 2;
    orow = 1; ocol = 1; base = 50;
    run_case("R2");
    // wrap on both edges
    clear_cfg(); L[0] = 6; dr[0] = 1; orow = -2; ocol = -1; rl = 4; cl = 3; base = 20;
    run_case("R6");
    clear_cfg(); L[0] = 5; dc[0] = 1; ocol = 1; rl = 4; cl = 3; base = 20;
    run_case("R6");
    // zero fill, same walks
    clear_cfg(); L[0] = 6; dr[0] = 1; orow = -2; ocol = 1; rl = 4; cl = 3; base = 20; zm = 1'b1;
    run_case("R7");
    clear_cfg(); L[0] = 5; dc[0] = 1; rl = 4; cl = 3; base = 9; zm = 1'b1;
    run_case("R7");
    // empty transfer
    clear_cfg(); L[1] = 4; dr[1] = 1;
    run_case("R5");
    // gap in the level list stops the nest
    clear_cfg(); L[0] = 3; dr[0] = 1; L[2] = 5; dc[2] = 1; base = 11;
    run_case("R4");

    // sweep on a 3x3 array
    for (int a = 1; a <= 3; a++)
      for (int b = 0; b <= 2; b++)
        for (int sr = -1; sr <= 1; sr++)
          for (int sc = -1; sc <= 1; sc++)
            for (int m = 0; m <= 1; m++) begin
              clear_cfg();
              L[0] = a; dr[0] = sr; L[1] = b; dc[1] = sc; dr[1] = 1;
              rl = 3; cl = 3; base = 40; zm = m[0];
              run_case("R2");
            end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule